// File: doc/BRIEF.md
# Delay-Slot Branch Resolution Unit

When an instruction that sits in the delay slot of a branch or jump takes an exception, the saved exception PC points at the branch word, not at the faulting instruction. Before the handler can return, something has to work out where execution should really resume. This block does that job. It receives the exception PC, fetches the branch word through a request/response memory port, and reads the two source operands through a pair of register-file read ports. It also samples the floating-point control/status word. From these it computes the resume address and any link-register write the branch would have made.

It handles five groups of control transfer:

- register-indirect jumps;
- region jumps with a 26-bit target;
- two-register and zero-compare branches;
- the sign-test branch group selected by the rt field;
- coprocessor-1 condition branches, for all eight condition bits.

Branch-likely forms resolve exactly as their ordinary counterparts do. Two cases end the operation early: a misaligned exception PC and a failed fetch. In both the block reports a fault and leaves the PC as it was. An operation starts with a one-cycle `start` pulse while the unit is idle. It ends with a one-cycle `done` pulse, and every result output is valid in that cycle.

Top module: `slot_resolver`

## Requirements
- R1: When `start` is sampled while idle and `epc_in[1:0]` is non-zero, the following cycle shows `done`=1 and `align_fault`=1, with `new_epc` equal to `epc_in`. No memory request is ever raised for that operation and `link_we` stays 0.
- R2: For an aligned PC, `mem_req` goes high with `mem_addr` equal to the PC. Both stay unchanged until `mem_rvalid`. If `mem_err` is 1 in the response cycle, the next cycle shows `done`=1 and `fetch_fault`=1, with `new_epc` equal to the PC and `link_we`=0.
- R3: A taken conditional branch resumes at PC+4 plus the sign-extended 16-bit offset (instruction bits 15:0) shifted left by two. A branch that is not taken resumes at PC+8.
- R4: Opcode 0 with function code 8 (bits 5:0) resumes at the rs value (rs in bits 25:21). Function code 9 does the same and also writes PC+8 to the register named in bits 15:11.
- R5: Opcodes 2 and 3 resume at bits 31:28 of PC+4 joined with the 26-bit target shifted left by two. Opcode 3 also writes PC+8 to register 31.
- R6: Opcode 1 selects a branch by its rt field (bits 20:16). Codes 0, 2, 16 and 18 branch when rs is negative. Codes 1, 3, 17 and 19 branch when rs is zero or positive. Codes 16 to 19 write PC+8 to register 31 whether or not the branch is taken.
- R7: Opcode 4 branches when rs equals rt, and opcode 5 branches when they differ. Opcode 6 branches when rs as a signed value is at most zero, and opcode 7 when it is above zero. Opcodes 6 and 7 ignore the rt register.
- R8: The likely opcodes 20, 21, 22 and 23 resolve exactly as opcodes 4, 5, 6 and 7.
- R9: Opcode 17 tests one bit of `fcsr_in`. That bit is 23 when rt[4:2] is zero and 24+rt[4:2] otherwise. When rt[0]=0 the branch is taken if the bit is clear; when rt[0]=1 it is taken if the bit is set.
- R10: A register index of 0 reads as zero whatever the register file returns. A link whose destination index is 0 produces `link_we`=0.
- R11: An unrecognised opcode, SPECIAL function code or rt code in opcode 1 still produces `done`. In that case `new_epc` equals the PC and `link_we`=0.
- R12: After the edge that accepts an error-free fetch response, `done` is 0 for one cycle and then 1 for exactly one cycle. `link_we` and both fault flags are valid only in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (honoured when idle) |
| epc_in | input | 32 | Exception PC pointing at the branch word |
| fcsr_in | input | 32 | Floating-point control/status word |
| mem_req | output | 1 | Instruction fetch request |
| mem_addr | output | 32 | Fetch address |
| mem_rvalid | input | 1 | Fetch response valid |
| mem_rdata | input | 32 | Fetched instruction word |
| mem_err | input | 1 | Fetch response carries an error |
| rf_raddr_a | output | 5 | Register read index, port A (rs) |
| rf_rdata_a | input | 32 | Register read data, port A (same cycle) |
| rf_raddr_b | output | 5 | Register read index, port B (rt) |
| rf_rdata_b | input | 32 | Register read data, port B (same cycle) |
| done | output | 1 | One-cycle completion pulse |
| new_epc | output | 32 | Resume address, valid with done |
| link_we | output | 1 | Link register write enable, with done |
| link_idx | output | 5 | Link register index |
| link_data | output | 32 | Link value (PC+8) |
| align_fault | output | 1 | Misaligned PC, with done |
| fetch_fault | output | 1 | Fetch error, with done |

## Verification
The properties assume that `start` is not raised in the same cycle as a `done` pulse. They also assume that `mem_rdata` and `mem_err` are meaningful only while `mem_rvalid` is high, and that register reads return data in the same cycle without any handshake. The stimulus respects all of this. Every operation waits for its `done` pulse and one further idle cycle before the next `start`. Fetch replies are produced only while `mem_req` is high, either at once or after a set number of wait cycles. The register file is a combinational array in which entry 0 always holds a non-zero value, so that any failure to force index 0 to zero shows up.

// File: rtl/slot_resolver_pkg.sv
`timescale 1ns/1ps
package slot_resolver_pkg;

    localparam int XLEN     = 32;
    localparam int REG_AW   = 5;
    localparam int OFF_W    = 16;
    localparam int TGT_W    = 26;
    localparam int REGION_W = 4;
    localparam int FPSEL_W  = 3;
    localparam int FP_BIT_BASE = 23;
    localparam int FP_BIT_ALT  = 24;
    localparam logic [REG_AW-1:0] RA_REG = REG_AW'(31);

    // primary opcodes
    localparam logic [5:0] OPC_SPECIAL = 6'd0;
    localparam logic [5:0] OPC_SIGNGRP = 6'd1;
    localparam logic [5:0] OPC_J       = 6'd2;
    localparam logic [5:0] OPC_JAL     = 6'd3;
    localparam logic [5:0] OPC_BEQ     = 6'd4;
    localparam logic [5:0] OPC_BNE     = 6'd5;
    localparam logic [5:0] OPC_BLEZ    = 6'd6;
    localparam logic [5:0] OPC_BGTZ    = 6'd7;
    localparam logic [5:0] OPC_COP1    = 6'd17;
    localparam logic [5:0] OPC_BEQ_LK  = 6'd20;
    localparam logic [5:0] OPC_BNE_LK  = 6'd21;
    localparam logic [5:0] OPC_BLEZ_LK = 6'd22;
    localparam logic [5:0] OPC_BGTZ_LK = 6'd23;

    localparam logic [5:0] FN_JR   = 6'd8;
    localparam logic [5:0] FN_JALR = 6'd9;

    // sign-test group selectors (rt field)
    localparam logic [4:0] SG_LTZ    = 5'd0;
    localparam logic [4:0] SG_GEZ    = 5'd1;
    localparam logic [4:0] SG_LTZ_LK = 5'd2;
    localparam logic [4:0] SG_GEZ_LK = 5'd3;
    localparam logic [4:0] SG_LTZ_AL = 5'd16;
    localparam logic [4:0] SG_GEZ_AL = 5'd17;
    localparam logic [4:0] SG_LTZ_AK = 5'd18;
    localparam logic [4:0] SG_GEZ_AK = 5'd19;

    typedef enum logic [1:0] {
        FLOW_HOLD,
        FLOW_REG,
        FLOW_REGION,
        FLOW_REL
    } flow_e;

    typedef enum logic [2:0] {
        CMP_EQ,
        CMP_NE,
        CMP_LEZ,
        CMP_GTZ,
        CMP_LTZ,
        CMP_GEZ,
        CMP_FPCLR,
        CMP_FPSET
    } cmp_e;

    typedef struct packed {
        flow_e              flow;
        cmp_e               cmp;
        logic               link;
        logic [REG_AW-1:0]  link_idx;
        logic [FPSEL_W-1:0] fp_sel;
        logic [OFF_W-1:0]   off;
        logic [TGT_W-1:0]   tgt;
    } ctl_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_EXEC
    } state_e;

    function automatic logic [XLEN-1:0] rel_disp(input logic [OFF_W-1:0] imm);
        return {{(XLEN-OFF_W-2){imm[OFF_W-1]}}, imm, 2'b00};
    endfunction

    function automatic logic [4:0] fp_bit_index(input logic [FPSEL_W-1:0] sel);
        if (sel == '0)
            return 5'(FP_BIT_BASE);
        return 5'(FP_BIT_ALT + int'(sel));
    endfunction

endpackage

// File: rtl/slot_resolver_decode.sv
`timescale 1ns/1ps
module slot_resolver_decode
    import slot_resolver_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctl_t            ctl
);
    logic [5:0]        opc;
    logic [5:0]        fn;
    logic [REG_AW-1:0] rt_f;
    logic [REG_AW-1:0] rd_f;

    assign opc  = instr[31:26];
    assign fn   = instr[5:0];
    assign rt_f = instr[20:16];
    assign rd_f = instr[15:11];

    always_comb begin
        ctl          = '0;
        ctl.flow     = FLOW_HOLD;
        ctl.cmp      = CMP_EQ;
        ctl.link     = 1'b0;
        ctl.link_idx = RA_REG;
        ctl.fp_sel   = rt_f[4:2];
        ctl.off      = instr[OFF_W-1:0];
        ctl.tgt      = instr[TGT_W-1:0];
        case (opc)
            OPC_SPECIAL: begin
                if (fn == FN_JR) begin
                    ctl.flow = FLOW_REG;
                end else if (fn == FN_JALR) begin
                    ctl.flow     = FLOW_REG;
                    ctl.link     = 1'b1;
                    ctl.link_idx = rd_f;
                end
            end
            OPC_SIGNGRP: begin
                case (rt_f)
                    SG_LTZ, SG_LTZ_LK: begin
                        ctl.flow = FLOW_REL;
                        ctl.cmp  = CMP_LTZ;
                    end
                    SG_GEZ, SG_GEZ_LK: begin
                        ctl.flow = FLOW_REL;
                        ctl.cmp  = CMP_GEZ;
                    end
                    SG_LTZ_AL, SG_LTZ_AK: begin
                        ctl.flow = FLOW_REL;
                        ctl.cmp  = CMP_LTZ;
                        ctl.link = 1'b1;
                    end
                    SG_GEZ_AL, SG_GEZ_AK: begin
                        ctl.flow = FLOW_REL;
                        ctl.cmp  = CMP_GEZ;
                        ctl.link = 1'b1;
                    end
                    default: ctl.flow = FLOW_HOLD;
                endcase
            end
            OPC_J: ctl.flow = FLOW_REGION;
            OPC_JAL: begin
                ctl.flow = FLOW_REGION;
                ctl.link = 1'b1;
            end
            OPC_BEQ, OPC_BEQ_LK: begin
                ctl.flow = FLOW_REL;
                ctl.cmp  = CMP_EQ;
            end
            OPC_BNE, OPC_BNE_LK: begin
                ctl.flow = FLOW_REL;
                ctl.cmp  = CMP_NE;
            end
            OPC_BLEZ, OPC_BLEZ_LK: begin
                ctl.flow = FLOW_REL;
                ctl.cmp  = CMP_LEZ;
            end
            OPC_BGTZ, OPC_BGTZ_LK: begin
                ctl.flow = FLOW_REL;
                ctl.cmp  = CMP_GTZ;
            end
            OPC_COP1: begin
                ctl.flow = FLOW_REL;
                ctl.cmp  = rt_f[0] ? CMP_FPSET : CMP_FPCLR;
            end
            default: ctl.flow = FLOW_HOLD;
        endcase
    end
endmodule

// File: rtl/slot_resolver_cond.sv
`timescale 1ns/1ps
module slot_resolver_cond
    import slot_resolver_pkg::*;
(
    input  ctl_t            ctl,
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic [XLEN-1:0] fcsr,
    output logic            taken
);
    logic [4:0] fbit;
    logic       fval;
    logic       a_neg;
    logic       a_zero;

    assign fbit   = fp_bit_index(ctl.fp_sel);
    assign fval   = fcsr[fbit];
    assign a_neg  = opa[XLEN-1];
    assign a_zero = (opa == '0);

    always_comb begin
        case (ctl.cmp)
            CMP_EQ:    taken = (opa == opb);
            CMP_NE:    taken = (opa != opb);
            CMP_LEZ:   taken = a_neg || a_zero;
            CMP_GTZ:   taken = !a_neg && !a_zero;
            CMP_LTZ:   taken = a_neg;
            CMP_GEZ:   taken = !a_neg;
            CMP_FPCLR: taken = !fval;
            CMP_FPSET: taken = fval;
            default:   taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/slot_resolver_target.sv
`timescale 1ns/1ps
module slot_resolver_target
    import slot_resolver_pkg::*;
(
    input  ctl_t            ctl,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rs_val,
    input  logic            taken,
    output logic [XLEN-1:0] next_pc,
    output logic [XLEN-1:0] ret_pc
);
    logic [XLEN-1:0] seq_pc;
    logic [XLEN-1:0] br_pc;
    logic [XLEN-1:0] region_pc;

    assign seq_pc    = pc + XLEN'(4);
    assign ret_pc    = pc + XLEN'(8);
    assign br_pc     = seq_pc + rel_disp(ctl.off);
    assign region_pc = {seq_pc[XLEN-1 -: REGION_W], ctl.tgt, 2'b00};

    always_comb begin
        case (ctl.flow)
            FLOW_REG:    next_pc = rs_val;
            FLOW_REGION: next_pc = region_pc;
            FLOW_REL:    next_pc = taken ? br_pc : ret_pc;
            default:     next_pc = pc;
        endcase
    end
endmodule

// File: rtl/slot_resolver.sv
`timescale 1ns/1ps
module slot_resolver
    import slot_resolver_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [XLEN-1:0]   epc_in,
    input  logic [XLEN-1:0]   fcsr_in,
    output logic              mem_req,
    output logic [XLEN-1:0]   mem_addr,
    input  logic              mem_rvalid,
    input  logic [XLEN-1:0]   mem_rdata,
    input  logic              mem_err,
    output logic [REG_AW-1:0] rf_raddr_a,
    input  logic [XLEN-1:0]   rf_rdata_a,
    output logic [REG_AW-1:0] rf_raddr_b,
    input  logic [XLEN-1:0]   rf_rdata_b,
    output logic              done,
    output logic [XLEN-1:0]   new_epc,
    output logic              link_we,
    output logic [REG_AW-1:0] link_idx,
    output logic [XLEN-1:0]   link_data,
    output logic              align_fault,
    output logic              fetch_fault
);
    localparam int NPORT = 2;

    state_e            state_q;
    logic [XLEN-1:0]   epc_q;
    logic [XLEN-1:0]   instr_q;
    logic              done_q;
    logic              afault_q;
    logic              ffault_q;
    logic              lwe_q;
    logic [REG_AW-1:0] lidx_q;
    logic [XLEN-1:0]   ldata_q;
    logic [XLEN-1:0]   nepc_q;

    logic              accept_w;
    logic              misaligned_w;
    ctl_t              ctl_w;
    logic              taken_w;
    logic [XLEN-1:0]   next_pc_w;
    logic [XLEN-1:0]   ret_pc_w;

    logic [NPORT-1:0][REG_AW-1:0] ra_w;
    logic [NPORT-1:0][XLEN-1:0]   raw_w;
    logic [NPORT-1:0][XLEN-1:0]   opnd_w;

    assign accept_w     = (state_q == ST_IDLE) && start;
    assign misaligned_w = |epc_in[1:0];

    assign ra_w[0]  = instr_q[25:21];
    assign ra_w[1]  = instr_q[20:16];
    assign raw_w[0] = rf_rdata_a;
    assign raw_w[1] = rf_rdata_b;

    // index 0 is hard-wired to zero on every read port
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign opnd_w[p] = (ra_w[p] == '0) ? '0 : raw_w[p];
    end

    assign rf_raddr_a = ra_w[0];
    assign rf_raddr_b = ra_w[1];

    slot_resolver_decode u_dec (
        .instr (instr_q),
        .ctl   (ctl_w)
    );

    slot_resolver_cond u_cond (
        .ctl   (ctl_w),
        .opa   (opnd_w[0]),
        .opb   (opnd_w[1]),
        .fcsr  (fcsr_in),
        .taken (taken_w)
    );

    slot_resolver_target u_tgt (
        .ctl     (ctl_w),
        .pc      (epc_q),
        .rs_val  (opnd_w[0]),
        .taken   (taken_w),
        .next_pc (next_pc_w),
        .ret_pc  (ret_pc_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            epc_q    <= '0;
            instr_q  <= '0;
            done_q   <= 1'b0;
            afault_q <= 1'b0;
            ffault_q <= 1'b0;
            lwe_q    <= 1'b0;
            lidx_q   <= '0;
            ldata_q  <= '0;
            nepc_q   <= '0;
        end else begin
            done_q   <= 1'b0;
            afault_q <= 1'b0;
            ffault_q <= 1'b0;
            lwe_q    <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept_w) begin
                        epc_q <= epc_in;
                        if (misaligned_w) begin
                            done_q   <= 1'b1;
                            afault_q <= 1'b1;
                            nepc_q   <= epc_in;
                        end else begin
                            state_q <= ST_FETCH;
                        end
                    end
                end
                ST_FETCH: begin
                    if (mem_rvalid) begin
                        if (mem_err) begin
                            done_q   <= 1'b1;
                            ffault_q <= 1'b1;
                            nepc_q   <= epc_q;
                            state_q  <= ST_IDLE;
                        end else begin
                            instr_q <= mem_rdata;
                            state_q <= ST_EXEC;
                        end
                    end
                end
                ST_EXEC: begin
                    nepc_q  <= next_pc_w;
                    lwe_q   <= ctl_w.link && (ctl_w.link_idx != '0);
                    lidx_q  <= ctl_w.link_idx;
                    ldata_q <= ret_pc_w;
                    done_q  <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign mem_req     = (state_q == ST_FETCH);
    assign mem_addr    = epc_q;
    assign done        = done_q;
    assign new_epc     = nepc_q;
    assign link_we     = lwe_q;
    assign link_idx    = lidx_q;
    assign link_data   = ldata_q;
    assign align_fault = afault_q;
    assign fetch_fault = ffault_q;

endmodule

// File: rtl/slot_resolver_checker.sv
`timescale 1ns/1ps
module slot_resolver_checker (
    input logic        clk,
    input logic        rst,
    input logic        accept,
    input logic [31:0] epc_in,
    input logic [31:0] epc_hold,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic        mem_rvalid,
    input logic        mem_err,
    input logic        done,
    input logic [31:0] new_epc,
    input logic        link_we,
    input logic [4:0]  link_idx,
    input logic [31:0] link_data,
    input logic        align_fault,
    input logic        fetch_fault
);
    AST_ALIGN_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
        (accept && (epc_in[1:0] != 2'b00)) |=>
            (done && align_fault && !mem_req && !link_we && new_epc == $past(epc_in))); // R1

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R2

    AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R2

    AST_FETCH_ERR: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_rvalid && mem_err) |=>
            (done && fetch_fault && !link_we && new_epc == epc_hold)); // R2

    AST_LINK_RET: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (link_data == epc_hold + 32'd8)); // R4

    AST_LINK_NOT_ZERO: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (link_idx != 5'd0)); // R10

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_rvalid && !mem_err) |=> !done ##1 done); // R12

    AST_FLAGS_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        (align_fault || fetch_fault || link_we) |-> done); // R12

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (done && !accept) |=> !done); // R12
endmodule

bind slot_resolver slot_resolver_checker chk_i (
    .clk         (clk),
    .rst         (rst),
    .accept      (accept_w),
    .epc_in      (epc_in),
    .epc_hold    (epc_q),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_rvalid  (mem_rvalid),
    .mem_err     (mem_err),
    .done        (done),
    .new_epc     (new_epc),
    .link_we     (link_we),
    .link_idx    (link_idx),
    .link_data   (link_data),
    .align_fault (align_fault),
    .fetch_fault (fetch_fault)
);

// File: tb/slot_resolver_tb_top.sv
`timescale 1ns/1ps
module slot_resolver_tb_top;

    function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
        return {op[5:0], rs[4:0], rt[4:0], imm[15:0]};
    endfunction
    function automatic logic [31:0] enc_r(input int rs, input int rd, input int fn);
        return {6'd0, rs[4:0], 5'd0, rd[4:0], 5'd0, fn[5:0]};
    endfunction
    function automatic logic [31:0] enc_j(input int op, input int tgt);
        return {op[5:0], tgt[25:0]};
    endfunction

    typedef struct packed {
        logic [23:0] tag;
        logic [31:0] instr;
        logic [31:0] epc;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] fcsr;
        logic [31:0] exp_pc;
        logic        exp_we;
        logic [4:0]  exp_idx;
        logic [31:0] exp_data;
    } vec_t;

    localparam logic [31:0] E  = 32'h0040_1000;
    localparam logic [31:0] TK = 32'h0040_1044;
    localparam logic [31:0] NT = 32'h0040_1008;
    localparam logic [31:0] BK = 32'h0040_0FC4;
    localparam int NV = 29;

    localparam vec_t VECS [NV] = '{
        '{"R3",  enc_i(4,4,5,'h10),    E, 32'd7, 32'd7, 32'd0, TK, 1'b0, 5'd0, 32'd0},
        '{"R3",  enc_i(4,4,5,'h10),    E, 32'd7, 32'd8, 32'd0, NT, 1'b0, 5'd0, 32'd0},
        '{"R7",  enc_i(5,4,5,'hFFF0),  E, 32'd7, 32'd8, 32'd0, BK, 1'b0, 5'd0, 32'd0},
        '{"R7",  enc_i(6,4,5,'h10),    E, 32'd0, 32'd9, 32'd0, TK, 1'b0, 5'd0, 32'd0},
        '{"R7",  enc_i(7,4,5,'h10),    E, 32'h8000_0000, 32'd0, 32'd0, NT, 1'b0, 5'd0, 32'd0},
        '{"R7",  enc_i(7,4,0,'h10),    E, 32'd1, 32'd0, 32'd0, TK, 1'b0, 5'd0, 32'd0},
        '{"R6",  enc_i(1,4,0,'h10),    E, 32'hFFFF_FFFF, 32'd0, 32'd0, TK, 1'b0, 5'd0, 32'd0},
        '{"R6",  enc_i(1,4,1,'h10),    E, 32'hFFFF_FFFF, 32'd0, 32'd0, NT, 1'b0, 5'd0, 32'd0},
        '{"R6",  enc_i(1,4,16,'h10),   E, 32'd5, 32'd0, 32'd0, NT, 1'b1, 5'd31, NT},
        '{"R6",  enc_i(1,4,17,'h10),   E, 32'd0, 32'd0, 32'd0, TK, 1'b1, 5'd31, NT},
        '{"R8",  enc_i(20,4,5,'h10),   E, 32'd3, 32'd3, 32'd0, TK, 1'b0, 5'd0, 32'd0},
        '{"R8",  enc_i(23,4,0,'hFFF0), E, 32'd3, 32'd0, 32'd0, BK, 1'b0, 5'd0, 32'd0},
        '{"R8",  enc_i(21,4,5,'h10),   E, 32'd3, 32'd3, 32'd0, NT, 1'b0, 5'd0, 32'd0},
        '{"R8",  enc_i(1,4,19,'h10),   E, 32'hFFFF_FFFB, 32'd0, 32'd0, NT, 1'b1, 5'd31, NT},
        '{"R5",  enc_j(2,'h0123456),   E, 32'd0, 32'd0, 32'd0, 32'h0048_D158, 1'b0, 5'd0, 32'd0},
        '{"R5",  enc_j(3,'h3FFFFFF),   32'hAFFF_FFFC, 32'd0, 32'd0, 32'd0, 32'hBFFF_FFFC, 1'b1, 5'd31, 32'hB000_0004},
        '{"R4",  enc_r(4,0,8),         E, 32'h1234_5678, 32'd0, 32'd0, 32'h1234_5678, 1'b0, 5'd0, 32'd0},
        '{"R4",  enc_r(4,7,9),         E, 32'h0080_0000, 32'd0, 32'd0, 32'h0080_0000, 1'b1, 5'd7, NT},
        '{"R10", enc_r(4,0,9),         E, 32'h0050_0000, 32'd0, 32'd0, 32'h0050_0000, 1'b0, 5'd0, 32'd0},
        '{"R9",  enc_i(17,8,0,'h10),   E, 32'd0, 32'd0, 32'd0, TK, 1'b0, 5'd0, 32'd0},
        '{"R9",  enc_i(17,8,1,'h10),   E, 32'd0, 32'd0, 32'h0080_0000, TK, 1'b0, 5'd0, 32'd0},
        '{"R9",  enc_i(17,8,1,'h10),   E, 32'd0, 32'd0, 32'd0, NT, 1'b0, 5'd0, 32'd0},
        '{"R9",  enc_i(17,8,5,'h10),   E, 32'd0, 32'd0, 32'h0200_0000, TK, 1'b0, 5'd0, 32'd0},
        '{"R9",  enc_i(17,8,5,'h10),   E, 32'd0, 32'd0, 32'h0080_0000, NT, 1'b0, 5'd0, 32'd0},
        '{"R9",  enc_i(17,8,30,'h10),  E, 32'd0, 32'd0, 32'h7FFF_FFFF, TK, 1'b0, 5'd0, 32'd0},
        '{"R11", enc_i(8,4,5,'h10),    E, 32'd0, 32'd0, 32'd0, E, 1'b0, 5'd0, 32'd0},
        '{"R11", enc_r(4,3,32),        E, 32'd5, 32'd0, 32'd0, E, 1'b0, 5'd0, 32'd0},
        '{"R11", enc_i(1,4,4,'h10),    E, 32'd0, 32'd0, 32'd0, E, 1'b0, 5'd0, 32'd0},
        '{"R10", enc_i(4,0,5,'h10),    E, 32'd0, 32'd0, 32'd0, TK, 1'b0, 5'd0, 32'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] epc_in = '0;
    logic [31:0] fcsr_in = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;
    logic        mem_err;
    logic [4:0]  rf_raddr_a, rf_raddr_b;
    logic [31:0] rf_rdata_a, rf_rdata_b;
    logic        done, link_we, align_fault, fetch_fault;
    logic [31:0] new_epc, link_data;
    logic [4:0]  link_idx;

    logic [31:0] tb_rf [32];
    logic [31:0] tb_word = '0;
    logic        tb_err = 1'b0;
    int          resp_delay = 0;
    int          wcnt = 0;
    int          reqcnt = 0;
    int          n_chk = 0;
    int          n_fail = 0;

    // captured results of one operation
    int          got_cycles;
    int          addr_bad;
    logic [31:0] got_pc, got_data;
    logic        got_we, got_af, got_ff, got_done_after;
    logic [4:0]  got_idx;

    always #2.5 clk = ~clk;

    assign mem_rvalid = mem_req && (wcnt >= resp_delay);
    assign mem_rdata  = tb_word;
    assign mem_err    = tb_err;
    assign rf_rdata_a = tb_rf[rf_raddr_a];
    assign rf_rdata_b = tb_rf[rf_raddr_b];

    always @(posedge clk) begin
        if (mem_req) begin
            wcnt   <= wcnt + 1;
            reqcnt <= reqcnt + 1;
        end else begin
            wcnt <= 0;
        end
    end

    slot_resolver dut_i (
        .clk(clk), .rst(rst), .start(start), .epc_in(epc_in), .fcsr_in(fcsr_in),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .mem_err(mem_err),
        .rf_raddr_a(rf_raddr_a), .rf_rdata_a(rf_rdata_a),
        .rf_raddr_b(rf_raddr_b), .rf_rdata_b(rf_rdata_b),
        .done(done), .new_epc(new_epc), .link_we(link_we), .link_idx(link_idx),
        .link_data(link_data), .align_fault(align_fault), .fetch_fault(fetch_fault)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [31:0] instr, input logic [31:0] pc,
                          input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] fc, input int dly, input logic err);
        for (int i = 1; i < 32; i++) tb_rf[i] = 32'h0BAD_0000 + i;
        tb_rf[0] = 32'hDEAD_BEEF;
        if (instr[25:21] != 5'd0) tb_rf[instr[25:21]] = a;
        if (instr[20:16] != 5'd0 && instr[20:16] != instr[25:21]) tb_rf[instr[20:16]] = b;
        tb_word    = instr;
        tb_err     = err;
        fcsr_in    = fc;
        resp_delay = dly;
        epc_in     = pc;
        reqcnt     = 0;
        addr_bad   = 0;
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
        got_cycles = 0;
        while (!done && got_cycles < 50) begin
            if (mem_req && mem_addr !== pc) addr_bad++;
            @(negedge clk);
            got_cycles++;
        end
        got_pc  = new_epc;
        got_we  = link_we;
        got_idx = link_idx;
        got_data = link_data;
        got_af  = align_fault;
        got_ff  = fetch_fault;
        @(negedge clk);
        got_done_after = done;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL R12 watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) tb_rf[i] = '0;
        repeat (4) @(negedge clk);
        // reset state (R12: no pulse or flag while reset is held)
        chk("R12", "reset done", {31'd0, done}, 32'd0);
        chk("R2", "reset mem_req", {31'd0, mem_req}, 32'd0);
        chk("R12", "reset flags", {29'd0, link_we, align_fault, fetch_fault}, 32'd0);
        chk("R12", "reset new_epc", new_epc, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            string t;
            t = $sformatf("%s vec%0d", VECS[v].tag, v);
            run_op(VECS[v].instr, VECS[v].epc, VECS[v].a, VECS[v].b, VECS[v].fcsr, 0, 1'b0);
            chk(t, "new_epc", got_pc, VECS[v].exp_pc);
            chk(t, "link_we", {31'd0, got_we}, {31'd0, VECS[v].exp_we});
            if (VECS[v].exp_we) begin
                chk(t, "link_idx", {27'd0, got_idx}, {27'd0, VECS[v].exp_idx});
                chk(t, "link_data", got_data, VECS[v].exp_data);
            end
            chk("R12", "latency", got_cycles, 32'd2);
            chk("R12", "done single", {31'd0, got_done_after}, 32'd0);
            chk("R12", "no fault", {30'd0, got_af, got_ff}, 32'd0);
        end

        // R1: misaligned PC, both low-bit patterns
        run_op(enc_j(3, 'h10), 32'h0040_1002, 32'd0, 32'd0, 32'd0, 0, 1'b0);
        chk("R1", "cycles", got_cycles, 32'd0);
        chk("R1", "align_fault", {31'd0, got_af}, 32'd1);
        chk("R1", "new_epc", got_pc, 32'h0040_1002);
        chk("R1", "no fetch", reqcnt, 32'd0);
        chk("R1", "no link", {31'd0, got_we}, 32'd0);
        run_op(enc_j(2, 'h10), 32'h0040_1001, 32'd0, 32'd0, 32'd0, 0, 1'b0);
        chk("R1", "align_fault b0", {31'd0, got_af}, 32'd1);
        chk("R1", "new_epc b0", got_pc, 32'h0040_1001);
        chk("R1", "no fetch b0", reqcnt, 32'd0);

        // R2: fetch error with wait states
        run_op(enc_j(3, 'h10), E, 32'd0, 32'd0, 32'd0, 2, 1'b1);
        chk("R2", "fetch_fault", {31'd0, got_ff}, 32'd1);
        chk("R2", "cycles", got_cycles, 32'd3);
        chk("R2", "new_epc", got_pc, E);
        chk("R2", "no link", {31'd0, got_we}, 32'd0);
        chk("R2", "align clear", {31'd0, got_af}, 32'd0);

        // R2 / R12: slow response, address held, latency after acceptance
        run_op(enc_j(3, 'h0123456), E, 32'd0, 32'd0, 32'd0, 3, 1'b0);
        chk("R2", "addr held", addr_bad, 32'd0);
        chk("R12", "slow latency", got_cycles, 32'd5);
        chk("R5", "slow target", got_pc, 32'h0048_D158);
        chk("R5", "slow link", {26'd0, got_we, got_idx}, {26'd0, 1'b1, 5'd31});
        chk("R12", "slow single", {31'd0, got_done_after}, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule